// File: doc/BRIEF.md
# Serial Readback and Sleep Sequencer for a 24-bit Delta-Sigma Converter

This block sits on the host side of a delta-sigma converter whose single output pin serves two purposes. The pin is pulled low when a conversion result is ready, and the same pin then carries the result bits. The host owns the serial clock. The block watches the pin. When a result is ready and its output slot is free, it clocks the word in, most significant bit first, and offers it on a valid/ready stream.

Power-down and calibration are controlled only through the serial clock. To put the converter to sleep, the block raises the clock and holds it high for at least the converter's activation time. To ask the converter to calibrate itself on wakeup, the block gives exactly one clock more than the word length before that hold. Wakeup is a falling clock. After wakeup the block waits for fresh data. If the pin does not fall within the ready time for the kind of wakeup used, plus a margin, the block raises an error flag.

Every duration is a parameter counted in cycles of `clk`, which is expected to run at the converter clock rate. The default values correspond to the converter's nominal clock.

Top module: `adc_readback_ctrl`

## Requirements
- R1: While reset is held and just after it, `sclk` is low and `out_valid`, `asleep` and `timeout_err` are all 0.
- R2: When `adc_line` is low and `out_valid` is 0, the block gives WORD_W clock pulses. Each pulse is HALF_CYC cycles low followed by HALF_CYC cycles high. The line is sampled as `sclk` falls, most significant bit first. The word is then published on `out_data` (two's complement, bit WORD_W-1 is the sign) with `out_valid` = 1.
- R3: Back-pressure. While `out_valid` = 1 and `out_ready` = 0, `out_data` holds steady. A word transfers on a cycle where both are 1. No new readback starts while `out_valid` = 1, so `sclk` gives no pulse even if the line is low.
- R4: A `cmd_sleep` pulse during a readback, or while data is pending, sends `sclk` high at the next rising point and holds it there. The word that was cut short is never published.
- R5: A `cmd_sleep_cal` pulse during a readback, or while data is pending, lets the word finish and be published. The block then gives exactly WORD_W+1 falling edges in total before `sclk` is held high.
- R6: A sleep command of either kind is ignored when no readback is running and the line is high. In that case `sclk` stays low and `asleep` stays 0.
- R7: `asleep` rises only after `sclk` has been high for at least SLEEP_HOLD cycles in a row. While `asleep` = 1, `sclk` stays high.
- R8: `cmd_wake` while `asleep` = 1 drives `sclk` low and clears `asleep` on the next cycle. `cmd_wake` at any other time is ignored.
- R9: After a wakeup, if the line has not gone low within WAKE_READY+READY_MARGIN cycles (plain sleep) or CAL_READY+READY_MARGIN cycles (sleep with calibration), `timeout_err` rises. It stays set until the next wakeup that is honoured, and that wakeup clears it.
- R10: If the line falls within that window after a wakeup, the result is read and published normally, and `timeout_err` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, one cycle per converter clock period |
| rst_n | input | 1 | Asynchronous reset, active low |
| adc_line | input | 1 | Shared pin: low means ready, then carries the data bits |
| sclk | output | 1 | Serial clock driven to the converter |
| cmd_sleep | input | 1 | One-cycle request for plain sleep |
| cmd_sleep_cal | input | 1 | One-cycle request for sleep with calibration on wakeup |
| cmd_wake | input | 1 | One-cycle request to wake the converter |
| out_valid | output | 1 | Stream valid for the captured word |
| out_ready | input | 1 | Stream ready from the consumer |
| out_data | output | WORD_W | Captured word, two's complement |
| asleep | output | 1 | The converter is held in sleep |
| timeout_err | output | 1 | No data arrived in time after a wakeup |

## Verification
A converter model in the bench drives the shared pin with words of varied shape: a negative word with only its end bits set, the largest positive word, an alternating pattern and all zeros. These expose any bit-order, off-by-one or sampling-edge fault. Holding `out_ready` low while a second word is already pending separates correct back-pressure from a block that overwrites the slot or clocks early. A plain sleep cut into the middle of a word is contrasted with a calibrated sleep that counts exactly one clock past the word, and with a sleep taken while data is pending. Two timeouts with different windows show that the block chooses the right ready limit for each kind of wakeup.

// File: rtl/adc_rb_pkg.sv
package adc_rb_pkg;
  typedef enum logic [2:0] {
    RB_IDLE,
    RB_SHIFT,
    RB_HOLD,
    RB_SLEEP,
    RB_WAKE
  } rb_state_e;
endpackage

// File: rtl/adc_rb_timer.sv
// Up-counter that stops at a loaded limit; done while count >= limit.
module adc_rb_timer #(
  parameter int TW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [TW-1:0] limit,
  output logic          done
);
  logic [TW-1:0] cnt_q;
  logic [TW-1:0] lim_q;

  assign done = (cnt_q >= lim_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (start) begin
      cnt_q <= '0;
      lim_q <= limit;
    end else if (!done) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/adc_rb_shifter.sv
// Serial-in shift register, MSB arrives first.
module adc_rb_shifter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         sample,
  input  logic         din,
  output logic [W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
    end else if (clr) begin
      word <= '0;
    end else if (sample) begin
      word <= {word[W-2:0], din};
    end
  end
endmodule

// File: rtl/adc_rb_outslot.sv
// Single-entry output register with valid/ready handshake.
module adc_rb_outslot #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= din;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_readback_ctrl.sv
module adc_readback_ctrl
  import adc_rb_pkg::*;
#(
  parameter int WORD_W       = 24,
  parameter int HALF_CYC     = 2,
  parameter int SLEEP_HOLD   = 163430,
  parameter int WAKE_READY   = 176947,
  parameter int CAL_READY    = 518554,
  parameter int READY_MARGIN = 24576
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adc_line,
  output logic              sclk,
  input  logic              cmd_sleep,
  input  logic              cmd_sleep_cal,
  input  logic              cmd_wake,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              asleep,
  output logic              timeout_err
);
  localparam int WAKE_LIM = WAKE_READY + READY_MARGIN;
  localparam int CAL_LIM  = CAL_READY + READY_MARGIN;
  localparam int LIM_A    = (WAKE_LIM > CAL_LIM) ? WAKE_LIM : CAL_LIM;
  localparam int LIM_MAX  = (LIM_A > SLEEP_HOLD) ? LIM_A : SLEEP_HOLD;
  localparam int TW       = $clog2(LIM_MAX + 1);
  localparam int PH_W     = $clog2(HALF_CYC) + 1;
  localparam int FC_W     = $clog2(WORD_W + 2);

  rb_state_e         state_q, state_d;
  logic              sclk_q, sclk_d;
  logic [PH_W-1:0]   ph_q, ph_d;
  logic [FC_W-1:0]   fc_q, fc_d;
  logic              cal_q, cal_d;
  logic              slp_q, slp_d;
  logic              wcal_q, wcal_d;
  logic              err_q, err_d;

  logic              tmr_start, tmr_done;
  logic [TW-1:0]     tmr_limit;
  logic              sh_clr, sh_smp;
  logic [WORD_W-1:0] sh_word;
  logic              pub_load;
  logic [WORD_W-1:0] pub_data;
  logic              line_low, ph_end, any_sleep;

  assign line_low  = ~adc_line;
  assign ph_end    = (ph_q == PH_W'(HALF_CYC - 1));
  assign pub_data  = {sh_word[WORD_W-2:0], adc_line};
  assign any_sleep = cal_q | slp_q | cmd_sleep | cmd_sleep_cal;

  always_comb begin
    state_d   = state_q;
    sclk_d    = sclk_q;
    ph_d      = ph_q;
    fc_d      = fc_q;
    cal_d     = cal_q;
    slp_d     = slp_q;
    wcal_d    = wcal_q;
    err_d     = err_q;
    tmr_start = 1'b0;
    tmr_limit = TW'(SLEEP_HOLD);
    sh_clr    = 1'b0;
    sh_smp    = 1'b0;
    pub_load  = 1'b0;
    unique case (state_q)
      RB_IDLE: begin
        if (line_low) begin
          if (cmd_sleep) begin
            state_d   = RB_HOLD;
            sclk_d    = 1'b1;
            tmr_start = 1'b1;
            wcal_d    = 1'b0;
            cal_d     = 1'b0;
          end else begin
            if (cmd_sleep_cal) cal_d = 1'b1;
            if (!out_valid) begin
              state_d = RB_SHIFT;
              sh_clr  = 1'b1;
              ph_d    = '0;
              fc_d    = '0;
              sclk_d  = 1'b0;
              slp_d   = 1'b0;
            end
          end
        end
      end
      RB_SHIFT: begin
        if (cmd_sleep)     slp_d = 1'b1;
        if (cmd_sleep_cal) cal_d = 1'b1;
        if (ph_end) begin
          ph_d = '0;
          if (!sclk_q) begin
            // rising point: either the next data clock or the sleep hold
            if (slp_q || (cal_q && fc_q == FC_W'(WORD_W + 1))) begin
              state_d   = RB_HOLD;
              sclk_d    = 1'b1;
              tmr_start = 1'b1;
              wcal_d    = cal_q & ~slp_q;
              cal_d     = 1'b0;
              slp_d     = 1'b0;
            end else begin
              sclk_d = 1'b1;
            end
          end else begin
            // falling point: sample and count
            sclk_d = 1'b0;
            fc_d   = fc_q + 1'b1;
            if (fc_q < FC_W'(WORD_W)) sh_smp = 1'b1;
            if (fc_q == FC_W'(WORD_W - 1)) begin
              pub_load = 1'b1;
              if (!any_sleep) state_d = RB_IDLE;
            end
          end
        end else begin
          ph_d = ph_q + 1'b1;
        end
      end
      RB_HOLD: begin
        sclk_d = 1'b1;
        if (tmr_done) state_d = RB_SLEEP;
      end
      RB_SLEEP: begin
        if (cmd_wake) begin
          state_d   = RB_WAKE;
          sclk_d    = 1'b0;
          tmr_start = 1'b1;
          tmr_limit = wcal_q ? TW'(CAL_LIM) : TW'(WAKE_LIM);
          err_d     = 1'b0;
        end
      end
      RB_WAKE: begin
        if (line_low) begin
          state_d = RB_IDLE;
        end else if (tmr_done) begin
          err_d   = 1'b1;
          state_d = RB_IDLE;
        end
      end
      default: state_d = RB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RB_IDLE;
      sclk_q  <= 1'b0;
      ph_q    <= '0;
      fc_q    <= '0;
      cal_q   <= 1'b0;
      slp_q   <= 1'b0;
      wcal_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      sclk_q  <= sclk_d;
      ph_q    <= ph_d;
      fc_q    <= fc_d;
      cal_q   <= cal_d;
      slp_q   <= slp_d;
      wcal_q  <= wcal_d;
      err_q   <= err_d;
    end
  end

  adc_rb_timer #(.TW(TW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (tmr_start),
    .limit (tmr_limit),
    .done  (tmr_done)
  );

  adc_rb_shifter #(.W(WORD_W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (sh_clr),
    .sample (sh_smp),
    .din    (adc_line),
    .word   (sh_word)
  );

  adc_rb_outslot #(.W(WORD_W)) u_slot (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (pub_load),
    .din   (pub_data),
    .ready (out_ready),
    .valid (out_valid),
    .data  (out_data)
  );

  assign sclk        = sclk_q;
  assign asleep      = (state_q == RB_SLEEP);
  assign timeout_err = err_q;
endmodule

// File: rtl/adc_readback_ctrl_chk.sv
module adc_readback_ctrl_chk
  import adc_rb_pkg::*;
#(
  parameter int WORD_W     = 24,
  parameter int SLEEP_HOLD = 163430
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sclk,
  input logic              asleep,
  input logic              timeout_err,
  input logic              cmd_wake,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              adc_line,
  input rb_state_e         st,
  input logic              wcal
);
  localparam int HW = $clog2(SLEEP_HOLD + 2);
  localparam int FW = $clog2(WORD_W + 3);

  logic [HW-1:0] hi_c;
  logic [FW-1:0] falls_c;
  logic          prev_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_c    <= '0;
      falls_c <= '0;
      prev_s  <= 1'b0;
    end else begin
      prev_s <= sclk;
      if (!sclk) hi_c <= '0;
      else if (hi_c < HW'(SLEEP_HOLD)) hi_c <= hi_c + 1'b1;
      if (st == RB_IDLE) falls_c <= '0;
      else if (prev_s && !sclk && falls_c < FW'(WORD_W + 2)) falls_c <= falls_c + 1'b1;
    end
  end

  a_r3_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  a_r5_cal_clock_count: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RB_HOLD && $past(st) == RB_SHIFT && wcal) |-> falls_c == FW'(WORD_W + 1));

  a_r6_idle_no_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RB_IDLE && adc_line) |=> st != RB_HOLD);

  a_r7_min_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> hi_c >= HW'(SLEEP_HOLD));

  a_r7_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> sclk);

  a_r8_wake: assert property (@(posedge clk) disable iff (!rst_n)
    asleep && cmd_wake |=> !asleep && !sclk);

  a_r9_err_after_wake: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> !asleep && !sclk);
endmodule

bind adc_readback_ctrl adc_readback_ctrl_chk #(
  .WORD_W     (WORD_W),
  .SLEEP_HOLD (SLEEP_HOLD)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sclk        (sclk),
  .asleep      (asleep),
  .timeout_err (timeout_err),
  .cmd_wake    (cmd_wake),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .adc_line    (adc_line),
  .st          (state_q),
  .wcal        (wcal_q)
);

// File: tb/adc_readback_ctrl_bench.sv
module adc_readback_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W   = 24;
  localparam int HC  = 2;
  localparam int SH  = 40;
  localparam int WR  = 60;
  localparam int CR  = 150;
  localparam int MG  = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic adc_line = 1'b1;
  logic sclk, out_valid, asleep, timeout_err;
  logic cmd_sleep = 1'b0, cmd_sleep_cal = 1'b0, cmd_wake = 1'b0, out_ready = 1'b1;
  logic [W-1:0] out_data;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic [W-1:0] exp_q[$];

  // converter model state
  int go_cnt = 0, seen_cnt = 0;
  logic [W-1:0] go_word, cur;
  bit active = 0, ps = 0, pa = 0;
  int idx = 0, rd_falls = 0, rises_total = 0, hi_run = 0, sleep_falls = -1;
  // monitor state
  bit pv_valid = 0, pv_ready = 0;
  logic [W-1:0] pv_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_readback_ctrl #(
    .WORD_W(W), .HALF_CYC(HC), .SLEEP_HOLD(SH),
    .WAKE_READY(WR), .CAL_READY(CR), .READY_MARGIN(MG)
  ) u_adc_readback_ctrl (
    .clk(clk), .rst_n(rst_n), .adc_line(adc_line), .sclk(sclk),
    .cmd_sleep(cmd_sleep), .cmd_sleep_cal(cmd_sleep_cal), .cmd_wake(cmd_wake),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .asleep(asleep), .timeout_err(timeout_err)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // converter model followed by per-clock monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (go_cnt != seen_cnt) begin
        seen_cnt = go_cnt; cur = go_word; active = 1; idx = 0; rd_falls = 0;
        adc_line = 1'b0;
      end else begin
        if (sclk && !ps) begin
          rises_total++;
          if (active && idx < W) begin adc_line = cur[W-1-idx]; idx++; end
        end
        if (!sclk && ps) begin
          rd_falls++;
          if (rd_falls >= W) begin adc_line = 1'b1; active = 0; end
        end
      end
      if (sclk) hi_run++; else hi_run = 0;
      if (hi_run == 2*HC + 2) begin sleep_falls = rd_falls; adc_line = 1'b1; active = 0; end
      ps = sclk;

      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk(0, "R2 R4 unexpected word", longint'(out_data), 0);
        else begin
          logic [W-1:0] e;
          e = exp_q.pop_front();
          chk(out_data == e, "R2 word", longint'(out_data), longint'(e));
        end
      end
      if (pv_valid && !pv_ready)
        chk(out_valid && out_data == pv_data, "R3 held word", longint'(out_data), longint'(pv_data));
      chk(!asleep || sclk, "R7 sclk high while asleep", sclk, 1);
      if (asleep && !pa) chk(hi_run >= SH, "R7 hold length", hi_run, SH);
      pa = asleep; pv_valid = out_valid; pv_ready = out_ready; pv_data = out_data;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 100000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
      finish_run();
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic present(input logic [W-1:0] w, input bit push);
    @(posedge clk); #2;
    go_word = w; go_cnt++;
    if (push) exp_q.push_back(w);
  endtask

  task automatic pulse(input int which);
    @(posedge clk); #2;
    case (which)
      0: cmd_sleep = 1'b1;
      1: cmd_sleep_cal = 1'b1;
      default: cmd_wake = 1'b1;
    endcase
    @(posedge clk); #2;
    cmd_sleep = 1'b0; cmd_sleep_cal = 1'b0; cmd_wake = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_ready(input logic r);
    @(posedge clk); #2; out_ready = r;
  endtask

  task automatic wait_empty(input string req);
    for (int i = 0; i < 1000 && (exp_q.size() != 0 || out_valid); i++) @(negedge clk);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  task automatic wait_asleep(input string req);
    for (int i = 0; i < 2000 && !asleep; i++) @(negedge clk);
    chk(asleep, req, asleep, 1);
  endtask

  task automatic time_err(input int lim, input string req);
    int n = 0;
    while (!timeout_err && n < 1000) begin @(negedge clk); n++; end
    chk(n >= lim && n <= lim + 3, req, n, lim);
  endtask

  initial begin
    tick(4);
    chk(!sclk && !out_valid && !asleep && !timeout_err, "R1 in reset",
        {sclk, out_valid, asleep, timeout_err}, 0);
    @(posedge clk); #2; rst_n = 1'b1;
    tick(2);
    chk(!sclk && !out_valid && !asleep && !timeout_err, "R1 after reset",
        {sclk, out_valid, asleep, timeout_err}, 0);

    // R6: sleep requests with nothing pending
    pulse(0); pulse(1); tick(10);
    chk(!sclk && !asleep, "R6 sleep ignored", {sclk, asleep}, 0);

    // R2: varied words
    present(24'h800001, 1); wait_empty("R2 negative word");
    present(24'h7FFFFF, 1); wait_empty("R2 max positive");
    present(24'hA5A5A5, 1); wait_empty("R2 alternating");
    present(24'h000000, 1); wait_empty("R2 zero");

    // R3: back-pressure
    set_ready(1'b0);
    present(24'h123456, 1);
    for (int i = 0; i < 500 && !out_valid; i++) @(negedge clk);
    present(24'h654321, 1);
    begin
      int r0;
      tick(2); r0 = rises_total; tick(30);
      chk(rises_total == r0 && !sclk, "R3 no readback while full", rises_total - r0, 0);
    end
    set_ready(1'b1);
    wait_empty("R3 both words delivered");

    // R4: plain sleep mid-word
    present(24'hFEDCBA, 0);
    for (int i = 0; i < 500 && idx < 10; i++) @(negedge clk);
    pulse(0);
    wait_asleep("R4 sleep entered");
    chk(sleep_falls < W, "R4 cut short", sleep_falls, W);
    tick(50);
    chk(sclk && asleep, "R7 stays asleep", {sclk, asleep}, 3);
    pulse(2);
    chk(!sclk && !asleep, "R8 wake", {sclk, asleep}, 0);
    tick(30);
    present(24'h0F0F0F, 1); wait_empty("R10 data after wake");
    chk(!timeout_err, "R10 no error", timeout_err, 0);

    // R5: calibrated sleep, then R9 long timeout
    present(24'h3C3C3C, 1); tick(2);
    pulse(1);
    wait_asleep("R5 sleep entered");
    chk(sleep_falls == W + 1, "R5 clock count", sleep_falls, W + 1);
    wait_empty("R5 word published");
    pulse(2);
    chk(!sclk && !asleep, "R8 wake after cal", {sclk, asleep}, 0);
    time_err(CR + MG, "R9 cal timeout");

    present(24'h00FF00, 1); wait_empty("R2 read after timeout");
    pulse(2); tick(5);
    chk(!sclk && !asleep && timeout_err, "R8 wake ignored",
        {sclk, asleep, timeout_err}, 1);

    // R4 pending-data sleep, then R9 plain timeout and clear
    set_ready(1'b0);
    present(24'hC00003, 1);
    for (int i = 0; i < 500 && !out_valid; i++) @(negedge clk);
    present(24'h111111, 0); tick(5);
    pulse(0);
    wait_asleep("R4 pending sleep");
    chk(sleep_falls == 0, "R4 no clocks before hold", sleep_falls, 0);
    set_ready(1'b1);
    wait_empty("R3 word delivered while asleep");
    pulse(2);
    chk(!timeout_err && !sclk, "R9 cleared by wake", timeout_err, 0);
    time_err(WR + MG, "R9 plain timeout");

    tick(5);
    finish_run();
  end
endmodule